// File: doc/BRIEF.md
# Programmable Sound Envelope Generator

This block makes the 5-bit amplitude envelope of a programmable sound generator. A 32-step level counter moves once per step interval. The interval is a programmable number of enabled master-clock ticks. Four shape bits decide how the ramps behave:

- the first ramp rises or falls;
- the pattern stops after one ramp, or keeps going;
- a repeating pattern restarts as a sawtooth or reverses into a triangle;
- the output can freeze once the first ramp ends.

A single-cycle restart pulse is raised whenever the shape is written. It clears the interval timer and loads the starting level. All pins are plain control and data levels. No stream passes through the block, so there is no valid/ready handshake and no back-pressure: `level` is a continuously valid register output.

The step interval is 8·EP enabled ticks, where EP is the 16-bit `period`. One full 32-step pattern therefore takes 256·EP ticks. The shape bits are decoded from `shape` as follows:

- bit 3: continue
- bit 2: attack
- bit 1: alternate
- bit 0: hold

Top module: `env_shaper`

## Requirements
- R1: While reset is low, and afterwards until the first restart, `level` is 0 and does not change, whatever `tick_en` does.
- R2: On the clock edge that samples `restart`=1, `level` becomes 0 if shape bit 2 (attack) is 1, or 31 if it is 0. Any earlier pattern is discarded.
- R3: After a restart, the n-th level step happens on the edge that samples the (8·EP·n)-th `tick_en`=1 after the restart edge. A `tick_en` of 1 on the restart edge itself is not counted. Cycles with `tick_en`=0 are not counted, and `level` holds between steps.
- R4: A `period` of 0 gives the same timing as a `period` of 1.
- R5: During the first 32-step cycle, each step moves `level` by +1 when attack is 1 and by -1 when attack is 0.
- R6: With continue (bit 3) = 0, the step after the first ramp ends sets `level` to 0, and `level` stays 0. This holds for any attack, alternate and hold value.
- R7: With continue=1, hold=0, alternate=0, the ramp repeats: after its end value it wraps to its start value (31→0 rising, 0→31 falling).
- R8: With continue=1, hold=0, alternate=1, each cycle reverses direction. The end value of one cycle is also the first value of the next, so every cycle is still 32 steps long.
- R9: With continue=1, hold=1, alternate=0, `level` freezes at the end value of the first ramp.
- R10: With continue=1, hold=1, alternate=1, the step after the first ramp ends moves `level` to the opposite extreme, and it freezes there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Master-clock enable; one tick per cycle when high |
| period | input | 16 | Envelope period EP (0 treated as 1) |
| shape | input | 4 | Bit 3 continue, bit 2 attack, bit 1 alternate, bit 0 hold |
| restart | input | 1 | One-cycle pulse issued when the shape is written |
| level | output | 5 | Envelope amplitude E4..E0 |

## Verification
A restart and a step can fall in the same cycle. Step boundaries and pattern ends can also coincide with ticks being withheld. The bench starts every shape with a restart while `tick_en` is held high, so the tick on the restart edge must be discarded. Each step position is then judged twice: one cycle before the step, where `level` must still hold, and on the step cycle itself. This pins the step timing to the exact edge. In one run `tick_en` is held low for a stretch right after a step, and every later expected edge moves by exactly the number of withheld ticks.

// File: rtl/env_pkg.sv
package env_pkg;
  localparam int LVL_W = 5;

  typedef struct packed {
    logic cont;
    logic att;
    logic alt;
    logic hold;
  } env_shape_t;
endpackage

// File: rtl/env_step_timer.sv
module env_step_timer #(
  parameter int PERIOD_W = 16,
  parameter int PRE_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                restart,
  input  logic [PERIOD_W-1:0] period,
  output logic                step
);
  localparam int CW = PERIOD_W + PRE_LOG2;

  logic [CW-1:0]       cnt;
  logic [PERIOD_W-1:0] eff_m1;
  logic [CW-1:0]       limit;

  // A zero period behaves as one; the limit is EP*2^PRE_LOG2 - 1
  assign eff_m1 = (period == '0) ? '0 : period - 1'b1;

  generate
    if (PRE_LOG2 > 0) begin : g_pre
      assign limit = {eff_m1, {PRE_LOG2{1'b1}}};
    end else begin : g_nopre
      assign limit = eff_m1;
    end
  endgenerate

  // >= keeps the timer safe when the period shrinks mid-interval
  assign step = tick_en && !restart && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= '0;
    end else if (tick_en) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: a restart always clears the timer, so no step can follow on the next edge
  p_restart_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/env_sequencer.sv
module env_sequencer
  import env_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  env_shape_t       shape,
  output logic [LVL_W-1:0] level
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

  logic [LVL_W-1:0] lvl;
  logic             up;
  logic             frozen;
  logic             at_end;

  assign at_end = up ? (lvl == TOP) : (lvl == '0);
  assign level  = lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl    <= '0;
      up     <= 1'b0;
      frozen <= 1'b1;
    end else if (restart) begin
      lvl    <= shape.att ? '0 : TOP;
      up     <= shape.att;
      frozen <= 1'b0;
    end else if (step && !frozen) begin
      if (!at_end) begin
        lvl <= up ? lvl + 1'b1 : lvl - 1'b1;
      end else if (!shape.cont) begin
        lvl    <= '0;
        frozen <= 1'b1;
      end else if (shape.hold) begin
        frozen <= 1'b1;
        if (shape.alt) lvl <= ~lvl;
      end else if (shape.alt) begin
        up <= ~up;
      end else begin
        lvl <= ~lvl;
      end
    end
  end

  // R2: starting level after restart follows the attack bit
  p_restart_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (level == ($past(shape.att) ? '0 : TOP)));

  // R3: without a step or restart the level holds
  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !step) |=> $stable(level));

  // R9: a frozen envelope ignores steps
  p_frozen_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !restart) |=> $stable(level));

  // R5: inside a ramp each step moves the level by exactly one
  p_unit_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !frozen && !at_end) |=>
      ((level == $past(lvl) + 1'b1) || (level == $past(lvl) - 1'b1)));
endmodule

// File: rtl/env_shaper.sv
module env_shaper
  import env_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int PRE_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic [PERIOD_W-1:0] period,
  input  logic [3:0]          shape,
  input  logic                restart,
  output logic [LVL_W-1:0]    level
);
  logic       step;
  env_shape_t shp;

  assign shp = env_shape_t'(shape);

  env_step_timer #(
    .PERIOD_W(PERIOD_W),
    .PRE_LOG2(PRE_LOG2)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .restart (restart),
    .period  (period),
    .step    (step)
  );

  env_sequencer u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (step),
    .shape   (shp),
    .level   (level)
  );

  // R1: level is zero while reset is applied
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (level == '0));
endmodule

// File: tb/sim_env_shaper.sv
module sim_env_shaper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [15:0] period = 16'd1;
  logic [3:0]  shape = 4'd0;
  logic        restart = 1'b0;
  logic [4:0]  level;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int         q_t[$];
  logic [4:0] q_v[$];
  string      q_r[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  env_shaper u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period(period),
    .shape(shape), .restart(restart), .level(level)
  );

  // Expected level n steps after restart, from the shape rules
  function automatic logic [4:0] exp_lvl(input logic [3:0] sh, input int n);
    int k;
    int p;
    bit rise;
    int e;
    k = n / 32;
    p = n % 32;
    if (k == 0) return sh[2] ? 5'(p) : 5'(31 - p);
    if (!sh[3]) return 5'd0;
    if (sh[0]) begin
      e = sh[2] ? 31 : 0;
      return sh[1] ? 5'(31 - e) : 5'(e);
    end
    rise = sh[1] ? (sh[2] ^ (k % 2 == 1)) : sh[2];
    return rise ? 5'(p) : 5'(31 - p);
  endfunction

  task automatic check(input logic [4:0] exp, input string req);
    n_cmp++;
    if (level !== exp) begin
      n_bad++;
      $display("FAIL %s: level=%0d expected=%0d (cycle %0d)", req, level, exp, cyc);
    end
  endtask

  // Monitor: pops expected items at their scheduled cycle
  always @(negedge clk) begin
    if (q_t.size() > 0 && q_t[0] == cyc) begin
      check(q_v[0], q_r[0]);
      void'(q_t.pop_front());
      void'(q_v.pop_front());
      void'(q_r.pop_front());
    end
  end

  task automatic push(input int t, input logic [4:0] v, input string r);
    q_t.push_back(t);
    q_v.push_back(v);
    q_r.push_back(r);
  endtask

  // Driver: restart a shape and schedule the expected trace
  task automatic run(input logic [3:0] sh, input int ep, input int nsteps,
                     input int pause_after, input int plen, input string req);
    int c;
    int len;
    int t;
    @(negedge clk);
    shape  = sh;
    period = 16'(ep);
    c   = cyc;
    len = 8 * ((ep == 0) ? 1 : ep);
    push(c + 1, exp_lvl(sh, 0), {req, " R2"});
    for (int n = 1; n <= nsteps; n++) begin
      t = c + 1 + n * len + ((plen > 0 && n > pause_after) ? plen : 0);
      push(t - 1, exp_lvl(sh, n - 1), {req, " R3"});
      push(t, exp_lvl(sh, n), req);
    end
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    if (plen > 0) begin
      while (cyc != c + 1 + pause_after * len) @(negedge clk);
      tick_en = 1'b0;
      repeat (plen) @(negedge clk);
      tick_en = 1'b1;
    end
    while (q_t.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(5'd0, "R1 in reset");
    @(negedge clk);
    rst_n   = 1'b1;
    tick_en = 1'b1;
    repeat (40) @(negedge clk);
    check(5'd0, "R1 idle after reset");

    run(4'b1100, 1, 70, 0, 0, "R7 R5 rising saw");
    run(4'b1000, 2, 40, 0, 0, "R7 R5 falling saw");
    run(4'b0000, 1, 40, 0, 0, "R6 fall once");
    run(4'b0111, 1, 40, 0, 0, "R6 rise once");
    run(4'b1010, 1, 70, 0, 0, "R8 triangle from top");
    run(4'b1110, 1, 70, 0, 0, "R8 triangle from zero");
    run(4'b1001, 1, 40, 0, 0, "R9 hold at end low");
    run(4'b1101, 1, 40, 0, 0, "R9 hold at end high");
    run(4'b1011, 1, 40, 0, 0, "R10 hold opposite high");
    run(4'b1111, 1, 40, 0, 0, "R10 hold opposite low");
    run(4'b1100, 0, 36, 0, 0, "R4 zero period");
    run(4'b1100, 3, 10, 3, 37, "R3 tick gating");
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 150000) @(negedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule